// File: doc/BRIEF.md
# AUX Reply Timeout Encoder

This block converts a requested reply timeout, given in microseconds, into the pair of settings an AUX receiver uses to time out a missing reply. The pair is a 7-bit length count and a 2-bit multiplier code, where the code selects a tick of 8, 16, 32 or 64 microseconds. The length is rounded up, so the programmed window is never shorter than the request. The block keeps the chosen pair in a register and drives it to the receiver until the next request arrives.

Every request is a single-cycle load strobe together with the timeout value. On the same update, the block reports in microseconds the timeout that the pair held before the load stood for. Software that changes the timeout for a while can use that value to put the old setting back later. A one-cycle valid pulse comes with each update.

Top module: `aux_reply_tmo_cfg`

## Requirements
- R1: After synchronous reset the held setting is multiplier code 0 with length 69, `prev_us_o` is 0 and `upd_valid_o` is low.
- R2: A load with a request of 0 us selects multiplier code 0 and length 69.
- R3: A load with a request from 1 to 1016 us selects multiplier code 0 and length ceil(t/8).
- R4: A load with a request from 1017 to 2032 us selects multiplier code 1 and length ceil(t/16).
- R5: A load with a request from 2033 to 4064 us selects multiplier code 2 and length ceil(t/32).
- R6: A load with a request above 4064 us selects multiplier code 3 and length ceil(t/64), limited to at most 127.
- R7: On each load, `prev_us_o` takes the value of the length held before the load times 8, 16, 32 or 64, for multiplier code 0, 1, 2 or 3.
- R8: Length, multiplier and previous value change only on the clock edge that samples a load. `upd_valid_o` is high for exactly the one cycle after that edge. When no load is present, changes on `tmo_us_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | One-cycle strobe that applies `tmo_us_i` |
| tmo_us_i | input | 16 | Requested timeout in microseconds |
| len_o | output | 7 | Held length count |
| mul_o | output | 2 | Held multiplier code (tick = 8 << code us) |
| prev_us_o | output | 13 | Timeout of the setting that was held before the last load |
| upd_valid_o | output | 1 | High for one cycle after each load |

## Verification
A wrong range choice or a wrong rounding in the encoder shows up at `len_o`/`mul_o` one cycle after the strobe. The requests just below and just above each 1016 us break are where an off-by-one step would show. A held register that is corrupted or left unloaded shows up twice: at the outputs right away, and again at `prev_us_o` on the next load, where the length and the code are read back as one microsecond product. The bench compares every update against both the new pair and the product of the pair it replaced.

// File: rtl/aux_tmo_pkg.sv
package aux_tmo_pkg;

    localparam int LEN_W       = 7;
    localparam int MUL_W       = 2;
    localparam int MUL_N       = 1 << MUL_W;
    localparam int BASE_SHIFT  = 3;
    localparam int PREV_W      = LEN_W + BASE_SHIFT + MUL_N - 1;
    localparam int RANGE_BREAK = 1016;
    localparam int DEF_LEN     = 69;
    localparam int LEN_MAX     = (1 << LEN_W) - 1;

    typedef struct packed {
        logic [MUL_W-1:0] mul;
        logic [LEN_W-1:0] len;
    } tmo_setting_t;

    function automatic tmo_setting_t default_setting();
        tmo_setting_t s;
        s.mul = '0;
        s.len = LEN_W'(DEF_LEN);
        return s;
    endfunction

    // Microseconds represented by a held setting.
    function automatic logic [PREV_W-1:0] setting_us(input tmo_setting_t s);
        return PREV_W'(s.len) << (BASE_SHIFT + int'(s.mul));
    endfunction

endpackage

// File: rtl/aux_tmo_encode.sv
module aux_tmo_encode
    import aux_tmo_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic [TIME_W-1:0] req_us,
    output tmo_setting_t      enc
);
    localparam int SUM_W = TIME_W + 1;

    logic [SUM_W-1:0] quot [MUL_N];
    logic [MUL_N-1:0] fits;
    logic [MUL_W-1:0] sel;
    logic [SUM_W-1:0] pick;

    // One candidate per tick size: ceiling divide and range test.
    for (genvar g = 0; g < MUL_N; g++) begin : g_step
        localparam int SH = BASE_SHIFT + g;
        assign quot[g] = ({1'b0, req_us} + SUM_W'((1 << SH) - 1)) >> SH;
        assign fits[g] = ({1'b0, req_us} <= SUM_W'(RANGE_BREAK << g));
    end

    always_comb begin
        sel = MUL_W'(MUL_N - 1);
        for (int k = MUL_N - 1; k >= 0; k--) begin
            if (fits[k]) sel = MUL_W'(k);
        end
        pick = quot[sel];
        if (req_us == '0) begin
            enc = default_setting();
        end else begin
            enc.mul = sel;
            enc.len = (pick > SUM_W'(LEN_MAX)) ? LEN_W'(LEN_MAX) : pick[LEN_W-1:0];
        end
    end

    // R6: clamping never yields zero for a nonzero request
    always_comb begin
        if (req_us != '0) a_r6_nonzero_len: assert (enc.len != '0);
    end

endmodule

// File: rtl/aux_tmo_hold.sv
module aux_tmo_hold
    import aux_tmo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  tmo_setting_t      next_set,
    input  logic [PREV_W-1:0] cur_us,
    output tmo_setting_t      held,
    output logic [PREV_W-1:0] prev_us,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= default_setting();
            prev_us <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= load;
            if (load) begin
                held    <= next_set;
                prev_us <= cur_us;
            end
        end
    end

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(held) && $stable(prev_us)));
    a_r8_valid_follows_load: assert property (@(posedge clk) disable iff (rst)
        load |=> valid);
    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        !load |=> !valid);

endmodule

// File: rtl/aux_reply_tmo_cfg.sv
module aux_reply_tmo_cfg
    import aux_tmo_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [TIME_W-1:0] tmo_us_i,
    output logic [LEN_W-1:0]  len_o,
    output logic [MUL_W-1:0]  mul_o,
    output logic [PREV_W-1:0] prev_us_o,
    output logic              upd_valid_o
);
    tmo_setting_t      enc_set;
    tmo_setting_t      held_set;
    logic [PREV_W-1:0] held_us;

    aux_tmo_encode #(.TIME_W(TIME_W)) u_enc (
        .req_us (tmo_us_i),
        .enc    (enc_set)
    );

    assign held_us = setting_us(held_set);

    aux_tmo_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (load_i),
        .next_set (enc_set),
        .cur_us   (held_us),
        .held     (held_set),
        .prev_us  (prev_us_o),
        .valid    (upd_valid_o)
    );

    assign len_o = held_set.len;
    assign mul_o = held_set.mul;

    a_r2_zero_default: assert property (@(posedge clk) disable iff (rst)
        (load_i && tmo_us_i == '0) |=> (len_o == LEN_W'(DEF_LEN) && mul_o == '0));
    a_r4_r5_r6_upper_floor: assert property (@(posedge clk) disable iff (rst)
        (upd_valid_o && mul_o != '0) |-> (len_o >= LEN_W'(64)));
    a_r7_prev_product: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (prev_us_o == (PREV_W'($past(len_o)) << (BASE_SHIFT + int'($past(mul_o))))));

endmodule

// File: tb/aux_reply_tmo_cfg_bench.sv
`timescale 1ns/1ps
module aux_reply_tmo_cfg_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [15:0] tmo_us_i = '0;
    logic [6:0]  len_o;
    logic [1:0]  mul_o;
    logic [12:0] prev_us_o;
    logic        upd_valid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    aux_reply_tmo_cfg u_aux_reply_tmo_cfg (
        .clk(clk), .rst(rst), .load_i(load_i), .tmo_us_i(tmo_us_i),
        .len_o(len_o), .mul_o(mul_o), .prev_us_o(prev_us_o), .upd_valid_o(upd_valid_o)
    );

    localparam int NV = 17;
    localparam int VT [NV] = '{0, 1, 8, 9, 1016, 1017, 2032, 2033, 4064, 4065,
                               5000, 8128, 8129, 65535, 500, 1500, 3000};
    localparam int VL [NV] = '{69, 1, 1, 2, 127, 64, 127, 64, 127, 64,
                               79, 127, 127, 127, 63, 94, 94};
    localparam int VM [NV] = '{0, 0, 0, 0, 0, 1, 1, 2, 2, 3,
                               3, 3, 3, 3, 0, 1, 2};
    localparam string VR [NV] = '{"R2", "R3", "R3", "R3", "R3", "R4", "R4", "R5", "R5", "R6",
                                  "R6", "R6", "R6", "R6", "R3", "R4", "R5"};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        int pl, pm;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 len", len_o, 69);
        check("R1 mul", mul_o, 0);
        check("R1 prev", prev_us_o, 0);
        check("R1 valid", upd_valid_o, 0);
        pl = 69; pm = 0;
        for (int i = 0; i < NV; i++) begin
            load_i = 1'b1; tmo_us_i = 16'(VT[i]);
            @(negedge clk);
            load_i = 1'b0; tmo_us_i = 16'(VT[i] ^ 16'h5a5a);
            check({VR[i], " len"}, len_o, VL[i]);
            check({VR[i], " mul"}, mul_o, VM[i]);
            check("R7 prev", prev_us_o, pl * (8 << pm));
            check("R8 valid high", upd_valid_o, 1);
            @(negedge clk);
            tmo_us_i = 16'hffff;
            check("R8 valid low", upd_valid_o, 0);
            check("R8 len held", len_o, VL[i]);
            check("R8 mul held", mul_o, VM[i]);
            check("R8 prev held", prev_us_o, pl * (8 << pm));
            pl = VL[i]; pm = VM[i];
        end
        // R1: reset in mid-run returns to default
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 re-reset len", len_o, 69);
        check("R1 re-reset mul", mul_o, 0);
        check("R1 re-reset prev", prev_us_o, 0);
        // R7 after reset: previous equals default 69*8
        load_i = 1'b1; tmo_us_i = 16'd2040;
        @(negedge clk);
        load_i = 1'b0;
        check("R7 prev default", prev_us_o, 552);
        check("R5 len", len_o, 64);
        check("R5 mul", mul_o, 2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule